// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This controller sits on the host side of an external NOR-style flash. Once an embedded program or erase has been started on the device, the system pulses `start`. The controller then issues status reads and decides whether the operation has finished. It compares the toggle bit, bit 6 of the low byte, between two reads in a row. When the toggle bit keeps changing, it looks at the timeout flag, bit 5 of the second read.

Each poll ends in one of three ways:

- **Done.** The toggle bit is stable across a pair of reads. The very next bus read may be array data.
- **Re-check.** The toggle bit moved while the timeout flag was high. The controller performs one more read pair, because toggling can stop in the same cycle that the flag rises.
- **Fail.** The toggle bit still moves on that extra pair, or too many toggling pairs have gone by with the flag low. The controller writes the reset command (data 0xF0) and raises `fail` once that write is acknowledged.

While polling, `busy` is high. Done and fail are held until the next `start` or `abort`. `abort` drops any poll at once, and the next `start` begins again from the first read of a fresh pair.

Top module: `toggle_poll`

## Requirements
- R1: While `rst_n` is low and after reset, `bus_req`, `done`, `fail` and `busy` are all low.
- R2: A `start` pulse while not busy makes `busy` high on the next cycle. The first two bus transactions are then reads (`bus_we`=0). A `start` while busy is ignored.
- R3: If bit 6 of the two reads of a pair is equal, `done` is raised with no further bus transaction.
- R4: If bit 6 differs and bit 5 of the second read is 0, a new read pair follows, provided the pair limit is not reached.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one further read pair follows. If bit 6 matches in it, `done` is raised.
- R6: If bit 6 still differs in that further pair, exactly one write of 0x00F0 (upper bits zero) is issued. `fail` rises only in the cycle after that write's `bus_ack`.
- R7: After `max_pairs` toggling pairs with bit 5 low, the reset write is issued and `fail` follows. A `max_pairs` of 0 acts as 1.
- R8: `abort` returns the controller to idle on the next cycle, with `bus_req`, `busy`, `done` and `fail` low. The next `start` begins with a fresh read pair.
- R9: A bus request, with its direction, is held until `bus_ack`. Only bits 6 and 5 of the read data affect the outcome.
- R10: `done` and `fail` hold until `start` or `abort`. A `start` issued while either is held begins a new poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll |
| abort | input | 1 | Leave polling, return to idle |
| max_pairs | input | CW | Limit on toggling read pairs with flag low |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write (reset command), 0 = status read |
| bus_wdata | output | DW | Write data, 0xF0 in the low byte |
| bus_ack | input | 1 | One-cycle completion of the current transaction |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| done | output | 1 | Operation completed |
| fail | output | 1 | Operation failed, reset command sent |
| busy | output | 1 | Poll in progress |

## Verification
The hardest path to reach is the re-check failure. It needs a toggling pair whose second read carries the timeout flag, followed by a pair that still toggles. A random status stream seldom lines these up, and it rarely lines up the flag-rise-with-stop success case either.

The bench uses a flash responder that returns a scripted list of status words with random acknowledge latency. Directed scripts force both re-check outcomes, the pair limit (including a limit of zero), and an abort in mid-poll. Random scripts, with noise in every other bit, cover the rest of the decision tree.

// File: rtl/toggle_poll.sv
module toggle_poll #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] max_pairs,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          fail,
  output logic          busy
);
  localparam int TGL = 6;
  localparam int TMO = 5;
  localparam logic [DW-1:0] RST_CMD = DW'(8'hF0);

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_RD2, S_RC1, S_RC2, S_RST, S_DONE, S_FAIL
  } st_t;

  st_t           st;
  logic          first_tgl;
  logic [CW-1:0] pairs;

  wire toggled  = bus_rdata[TGL] ^ first_tgl;
  wire at_limit = ({1'b0, pairs} + (CW+1)'(1)) >= {1'b0, max_pairs};
  wire unused_rd = ^{bus_rdata[DW-1:7], bus_rdata[4:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      first_tgl <= 1'b0;
      pairs     <= '0;
    end else if (abort) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            st    <= S_RD1;
            pairs <= '0;
          end
        S_RD1:
          if (bus_ack) begin
            first_tgl <= bus_rdata[TGL];
            st        <= S_RD2;
          end
        S_RD2:
          if (bus_ack) begin
            if (!toggled)            st <= S_DONE;
            else if (bus_rdata[TMO]) st <= S_RC1;
            else if (at_limit)       st <= S_RST;
            else begin
              pairs <= pairs + 1'b1;
              st    <= S_RD1;
            end
          end
        S_RC1:
          if (bus_ack) begin
            first_tgl <= bus_rdata[TGL];
            st        <= S_RC2;
          end
        S_RC2:
          if (bus_ack) st <= toggled ? S_RST : S_DONE;
        S_RST:
          if (bus_ack) st <= S_FAIL;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = st inside {S_RD1, S_RD2, S_RC1, S_RC2, S_RST};
  assign bus_we    = (st == S_RST);
  assign bus_wdata = bus_we ? RST_CMD : '0;
  assign busy      = bus_req;
  assign done      = (st == S_DONE);
  assign fail      = (st == S_FAIL);
endmodule

// File: rtl/toggle_poll_chk.sv
module toggle_poll_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic          bus_req,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          done,
  input logic          fail,
  input logic          busy
);
  AST_IDLE_OUT: assert property (@(posedge clk) !rst_n |=> !bus_req && !done && !fail && !busy); // R1
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, fail, busy})); // R2
  AST_DONE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(bus_ack && !bus_we)); // R3
  AST_FAIL_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) $rose(fail) |-> $past(bus_ack && bus_we)); // R6
  AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n) bus_req && bus_we |-> bus_wdata == DW'(8'hF0)); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) abort |=> !busy && !bus_req && !done && !fail); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bus_req && !bus_ack && !abort |=> bus_req && $stable(bus_we)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done || fail) && !start && !abort |=> $stable(done) && $stable(fail)); // R10
endmodule

bind toggle_poll toggle_poll_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_toggle_poll.sv
module sim_toggle_poll;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic [CW-1:0] max_pairs = '0;
  logic          bus_req, bus_we, bus_ack = 1'b0;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic          done, fail, busy;

  toggle_poll #(.DW(DW), .CW(CW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] seq [64];
  int rd_idx = 0, nwr = 0, lat = 0, ntot = 0, nfail = 0, cyc = 0;
  logic [DW-1:0] last_w = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input bit b6, input bit b5);
    logic [DW-1:0] v = DW'($urandom);
    v[6] = b6; v[5] = b5;
    return v;
  endfunction

  function automatic void predict(input int mp, output bit ok, output int nr);
    int i, pr, lim;
    i = 0; pr = 0; lim = (mp < 1) ? 1 : mp; ok = 0; nr = 0;
    for (int k = 0; k < 30; k++) begin
      if (seq[i][6] == seq[i+1][6]) begin ok = 1; nr = i + 2; return; end
      if (seq[i+1][5]) begin ok = (seq[i+2][6] == seq[i+3][6]); nr = i + 4; return; end
      pr++; i += 2;
      if (pr >= lim) begin ok = 0; nr = i; return; end
    end
  endfunction

  // flash responder
  initial begin
    forever begin
      @(negedge clk);
      bus_ack = 1'b0;
      if (bus_req && rst_n) begin
        if (lat > 0) lat--;
        else begin
          bus_ack = 1'b1;
          if (bus_we) begin nwr++; last_w = bus_wdata; end
          else begin bus_rdata = seq[rd_idx % 64]; rd_idx++; end
          lat = $urandom % 3;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
      end
    end
  end

  task automatic run_trial(input int mp, input string tag);
    bit eok; int enr; int w;
    predict(mp, eok, enr);
    max_pairs = CW'(mp);
    rd_idx = 0; nwr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, {tag, " R2 busy after start"}, int'(busy), 1);
    w = 0;
    while (!(done || fail) && w < 2000) begin @(negedge clk); w++; end
    chk(w < 2000, {tag, " no result"}, w, 2000);
    chk(done === eok && fail === !eok, {tag, " R3 R5 R6 R7 outcome done"}, int'(done), int'(eok));
    chk(rd_idx == enr, {tag, " R4 read count"}, rd_idx, enr);
    chk(nwr == (eok ? 0 : 1), {tag, " R6 R7 reset writes"}, nwr, eok ? 0 : 1);
    if (!eok) chk(last_w == 16'h00F0, {tag, " R6 write data"}, int'(last_w), 16'h00F0);
    repeat (3) @(negedge clk);
    chk(done === eok && bus_req === 1'b0, {tag, " R10 result held"}, int'(done), int'(eok));
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) seq[i] = mk($urandom % 2, 0);
    repeat (3) @(negedge clk);
    chk(!bus_req && !done && !fail && !busy, "R1 in reset", int'(bus_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !done && !fail && !busy, "R1 after reset", int'(busy), 0);

    seq[0] = mk(1, 0); seq[1] = mk(1, 0);
    run_trial(4, "R3 immediate");
    seq[0] = 16'hFFBF; seq[1] = 16'h0040 ^ 16'h0040; seq[1][6] = 1'b0;
    run_trial(4, "R9 noise bits");
    seq[0] = mk(0, 0); seq[1] = mk(1, 0); seq[2] = mk(1, 0); seq[3] = mk(0, 0);
    seq[4] = mk(1, 0); seq[5] = mk(1, 0);
    run_trial(5, "R4 repoll");
    seq[0] = mk(0, 0); seq[1] = mk(1, 1); seq[2] = mk(0, 1); seq[3] = mk(0, 1);
    run_trial(4, "R5 recheck ok");
    seq[0] = mk(0, 0); seq[1] = mk(1, 1); seq[2] = mk(0, 1); seq[3] = mk(1, 1);
    run_trial(4, "R6 recheck fail");
    for (int i = 0; i < 64; i++) seq[i] = mk(i % 2, 0);
    run_trial(3, "R7 limit 3");
    run_trial(0, "R7 limit 0");

    // R8 abort mid-poll then fresh start
    max_pairs = CW'(200); rd_idx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1 && !done && !fail, "R2 start ignored while busy", int'(busy), 1);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(!busy && !bus_req && !done && !fail, "R8 abort idle", int'(bus_req), 0);
    seq[0] = mk(0, 0); seq[1] = mk(0, 0);
    run_trial(3, "R8 fresh after abort");

    for (int t = 0; t < 200; t++) begin
      for (int i = 0; i < 64; i++) seq[i] = mk($urandom % 2, ($urandom % 5) == 0);
      run_trial($urandom % 9, "random");
    end

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule